// File: doc/BRIEF.md
# Forced Credit-Return Message Inserter

This block turns receive-buffer free events into credit-return messages for a packet link. Each virtual channel keeps separate command and data receive buffers. Every time the local receiver frees one of them, a pulse arrives on the matching bit of `free_pulse`. The block keeps a saturating pending count per counter. Once the stream is ready, it presents a message to the transmit multiplexer with `force_req` raised. The multiplexer gives that message priority over forwarded and locally issued packets.

The message is not sent again at every opportunity. A programmable interval (`ivl_cfg`) sets a minimum spacing between messages. Credits freed during that interval build up, so the next message returns several of them at once. A single message can carry only a bounded count per field. Anything above that bound stays pending for a later message. Putting the message on the wire is the multiplexer's job. This block only offers the field values and asks to be inserted at a packet boundary.

Top module: `crel_inserter`

## Requirements
- R1: After reset, `force_req` is 0, every message field is 0 and the interval timer is expired.
- R2: Counter index i = vc*NUM_TYPE + type, where type 0 is command and type 1 is data. Field i occupies `msg_fields[i*FIELD_W +: FIELD_W]` and shows min(pending[i], 2**FIELD_W-1). A pulse on `free_pulse[i]` raises pending[i] by one from the next cycle.
- R3: A pending count saturates at 2**CNT_W-1. A further pulse while it is saturated leaves it unchanged.
- R4: A message is sent in any cycle where `force_req` and `msg_taken` are both 1. In the following cycle, each pending count is reduced by the field value shown at the moment of sending, and the pulse of the sending cycle is added. Any surplus above the field limit stays pending.
- R5: `force_req` is 0 whenever `pkt_boundary` is 0, so a message never interrupts a packet.
- R6: When some count is pending, `pkt_boundary` is 1 and the interval has expired, `force_req` is 1 in that same cycle. A single pulse therefore yields a request in the very next cycle.
- R7: After a send with `ivl_cfg` = N, `force_req` stays 0 for the next N cycles.
- R8: With `ivl_cfg` = 0 there is no throttling, and messages may be sent on consecutive cycles.
- R9: Pulses that arrive while the block is throttled are accumulated. The first message after the interval ends carries all of them, up to the field limit.
- R10: `force_req` is 0 whenever no count is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_pulse | input | NUM_VC*NUM_TYPE | One pulse per freed receive buffer, one bit per counter |
| ivl_cfg | input | IVL_W | Minimum number of idle cycles after each message |
| pkt_boundary | input | 1 | Outgoing stream may start a new packet this cycle |
| msg_taken | input | 1 | Multiplexer inserts the offered message this cycle |
| force_req | output | 1 | Request to pre-empt the stream with a credit message |
| msg_fields | output | NUM_VC*NUM_TYPE*FIELD_W | Credit counts carried by the offered message |

## Verification
The hardest state to reach is a count pinned at saturation while the field limit also clips the message. Reaching it takes many pulses, and no drain can happen in between. The bench gets there by holding `pkt_boundary` low and pulsing one counter for twenty cycles. It then lets single messages drain the count in steps of the field limit. It also lands pulses inside a long throttle window, checking that the first message after the window carries the combined count.

// File: rtl/crel_pkg.sv
package crel_pkg;
  // Credits a message can return for a counter holding cnt
  function automatic int unsigned take_amt(int unsigned cnt, int unsigned fmax);
    return (cnt < fmax) ? cnt : fmax;
  endfunction

  // Pending count after removing dec and adding inc, clipped at cmax
  function automatic int unsigned next_pend(int unsigned cnt, int unsigned dec,
                                            int unsigned inc, int unsigned cmax);
    int unsigned t;
    t = cnt - dec + inc;
    return (t > cmax) ? cmax : t;
  endfunction
endpackage

// File: rtl/crel_pend_ctr.sv
module crel_pend_ctr #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned FIELD_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               send_i,
  output logic               busy_o,
  output logic [FIELD_W-1:0] take_o
);
  localparam int unsigned CNT_MAX   = (1 << CNT_W) - 1;
  localparam int unsigned FIELD_MAX = (1 << FIELD_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  int unsigned      take_w;
  int unsigned      dec_w;

  always_comb begin
    take_w = crel_pkg::take_amt(32'(cnt_q), FIELD_MAX);
    dec_w  = send_i ? take_w : 0;
    cnt_d  = CNT_W'(crel_pkg::next_pend(32'(cnt_q), dec_w, 32'(inc_i), CNT_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign take_o = FIELD_W'(take_w);

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(CNT_MAX) && inc_i && !send_i) |=> cnt_q == CNT_W'(CNT_MAX)); // R3
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (send_i && !inc_i && cnt_q != '0) |=> cnt_q < $past(cnt_q)); // R4
endmodule

// File: rtl/crel_ivl_timer.sv
module crel_ivl_timer #(
  parameter int unsigned IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IVL_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [IVL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i)); // R7
endmodule

// File: rtl/crel_inserter.sv
module crel_inserter #(
  parameter int unsigned NUM_VC   = 3,
  parameter int unsigned NUM_TYPE = 2,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned FIELD_W  = 2,
  parameter int unsigned IVL_W    = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_VC*NUM_TYPE-1:0]           free_pulse,
  input  logic [IVL_W-1:0]                     ivl_cfg,
  input  logic                                 pkt_boundary,
  input  logic                                 msg_taken,
  output logic                                 force_req,
  output logic [NUM_VC*NUM_TYPE*FIELD_W-1:0]   msg_fields
);
  localparam int unsigned NUM_CTR = NUM_VC * NUM_TYPE;

  // Internal events brought out by name for the assertions
  logic               send_ev;
  logic               ivl_expired;
  logic               any_pend;
  logic [NUM_CTR-1:0] busy_vec;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    crel_pend_ctr #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (free_pulse[i]),
      .send_i (send_ev),
      .busy_o (busy_vec[i]),
      .take_o (msg_fields[i*FIELD_W +: FIELD_W])
    );
  end

  crel_ivl_timer #(.IVL_W(IVL_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (send_ev),
    .load_val_i (ivl_cfg),
    .expired_o  (ivl_expired)
  );

  assign any_pend  = |busy_vec;
  assign force_req = any_pend && ivl_expired && pkt_boundary;
  assign send_ev   = force_req && msg_taken;

  AST_FORCE_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |-> msg_fields != '0); // R10
  AST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ev && ivl_cfg != '0) |=> !force_req); // R7
  AST_NO_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ev && ivl_cfg == '0) |=> ivl_expired); // R8
endmodule

// File: tb/crel_inserter_bench.sv
module crel_inserter_bench;
  localparam int NC = 6;
  localparam int FW = 2;
  localparam int FMAX = 3;
  localparam int CMAX = 15;

  logic clk = 0;
  logic rst_n = 0;
  logic [NC-1:0] free_pulse = '0;
  logic [7:0] ivl_cfg = '0;
  logic pkt_boundary = 0;
  logic msg_taken = 0;
  logic force_req;
  logic [NC*FW-1:0] msg_fields;

  int tests = 0;
  int fails = 0;
  int m_pend[NC];
  int m_ivl = 0;

  always #5 clk = ~clk;

  crel_inserter u_crel_inserter (
    .clk(clk), .rst_n(rst_n), .free_pulse(free_pulse), .ivl_cfg(ivl_cfg),
    .pkt_boundary(pkt_boundary), .msg_taken(msg_taken),
    .force_req(force_req), .msg_fields(msg_fields)
  );

  task automatic check(input string tag, input logic [NC*FW:0] act, input logic [NC*FW:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s force/fields actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive, compare against the model, advance the model
  task automatic step(input logic [NC-1:0] fr, input logic bnd, input logic tk,
                      input int ivl, input string tag);
    logic [NC*FW-1:0] ef;
    logic efrc;
    bit pend;
    bit snd;
    @(negedge clk);
    free_pulse = fr; pkt_boundary = bnd; msg_taken = tk; ivl_cfg = 8'(ivl);
    #1;
    pend = 0;
    for (int i = 0; i < NC; i++) begin
      ef[i*FW +: FW] = FW'((m_pend[i] > FMAX) ? FMAX : m_pend[i]);
      if (m_pend[i] > 0) pend = 1;
    end
    efrc = pend && (m_ivl == 0) && bnd;
    check(tag, {force_req, msg_fields}, {efrc, ef});
    snd = efrc && tk;
    for (int i = 0; i < NC; i++) begin
      m_pend[i] = m_pend[i] - (snd ? int'(ef[i*FW +: FW]) : 0) + int'(fr[i]);
      if (m_pend[i] > CMAX) m_pend[i] = CMAX;
    end
    if (snd) m_ivl = ivl;
    else if (m_ivl > 0) m_ivl--;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) m_pend[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step('0, 1, 0, 0, "R1");
    // R2, R6: one pulse gives a request next cycle with field 1
    step(6'b000001, 1, 0, 0, "R2");
    step('0, 1, 0, 0, "R6");
    step(6'b100000, 1, 0, 0, "R2");
    // R5: no request without a packet boundary
    step('0, 0, 1, 0, "R5");
    step('0, 0, 1, 0, "R5");
    // R8: send back to back with no throttling
    step('0, 1, 1, 0, "R8");
    step(6'b000100, 1, 1, 0, "R8");
    step('0, 1, 1, 0, "R8");
    // R10: nothing pending, no request
    step('0, 1, 1, 0, "R10");
    // R4: build 5 on counter 2, send 3, 2 stay pending
    for (int k = 0; k < 5; k++) step(6'b000100, 0, 0, 0, "R4");
    step('0, 1, 1, 0, "R4");
    step('0, 1, 0, 0, "R4");
    // R7, R9: interval 6, pulses inside the window accumulate
    step('0, 1, 1, 6, "R7");
    for (int k = 0; k < 6; k++) step(6'b010010, 1, 1, 6, "R7");
    step('0, 1, 0, 6, "R9");
    step('0, 1, 1, 6, "R9");
    // R3: saturate counter 5 with no boundary, then drain in limited steps
    for (int k = 0; k < 20; k++) step(6'b100000, 0, 0, 0, "R3");
    for (int k = 0; k < 8; k++) step('0, 1, 1, 0, "R3");
    // Mixed traffic over all requirements
    for (int k = 0; k < 400; k++)
      step(NC'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0, $urandom % 5, "R4/R6/R7");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule